// File: doc/BRIEF.md
# Output-Stationary Outer-Product Multiply-Accumulate Mesh

This block is a two-dimensional array of integer multiply-accumulate elements that builds matrix products as a running sum of outer products. On each accepted step, the mesh takes two slices. One is a column slice of the left matrix, with one value per mesh row. The other is a row slice of the right matrix, with one value per mesh column. Every element in row i multiplies the row-i value by the value of its own column, and adds the product to the partial sum it keeps. Partial sums never leave the elements until the whole K loop has finished.

Each element's accumulator is a pipeline of `PIPE_L` registers, and `PIPE_L` independent output tiles are interleaved through it. Step number t of a job belongs to tile `t mod PIPE_L`, so a partial sum comes back to its own adder exactly `PIPE_L` steps after it left. The inputs can therefore run at one step per cycle without stalling. When either input stream lacks data, the whole pipeline holds still. After the final step, the mesh stops accepting input. It streams out all `PIPE_L` tiles, each in row-major order, and clears each tile as it is handed off. It then accepts the next job.

The controller is a three-state machine:
- IDLE waits for the first step of a job and samples the K length.
- ACCUM takes the remaining steps.
- DRAIN emits the results.

The transitions are:
- first-step (IDLE to ACCUM).
- single-step-job (IDLE to DRAIN, when the first step is also the last).
- final-step (ACCUM to DRAIN).
- drain-done (DRAIN to IDLE, on the handshake of the last result).

Top module: `opm_mesh`

## Requirements
- R1: After reset, both input-ready outputs are 1 and `res_valid_o` is 0.
- R2: A step happens only on a cycle where `a_valid_i`, `b_valid_i` and the input ready are all 1. On any other cycle, the accumulator pipelines hold their contents, and the data on an invalid stream has no effect on the results.
- R3: Lane i of `a_col_i` (bits `[i*OP_W +: OP_W]`, unsigned) is the left operand of every element in mesh row i.
- R4: Lane j of `b_row_i` (bits `[j*OP_W +: OP_W]`, unsigned) is the right operand of every element in mesh column j.
- R5: Step t of a job (counting from 0) feeds tile `t mod PIPE_L` at K index `t div PIPE_L`. Tile s produces C_s[r][c] = sum over k of A_s[r][k]*B_s[k][c]. The input ready stays 1 for every step of a job, so the mesh accepts one step per cycle without stalls.
- R6: `k_last_i` holds K-1 and is sampled only on the first step of a job. A job is `(k_last_i+1)*PIPE_L` steps long, and changes to `k_last_i` during the job have no effect.
- R7: During draining, both input readies are 0 and `res_valid_o` is 1. The `PIPE_L*ROWS*COLS` results leave tile 0 first and are row-major within each tile. `res_last_o` is 1 only on the final result. After that result, the block returns to accepting input.
- R8: While `res_valid_o` is 1 and `res_ready_i` is 0, `res_valid_o`, `res_data_o` and `res_last_o` hold their values.
- R9: Each tile is cleared as it is handed off, so the results of one job never include values from an earlier job.
- R10: The accumulator format is narrow (16 bits, the default) or wide (32 bits), chosen at elaboration. Sums wrap modulo 2^ACC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| k_last_i | input | K_W | K steps minus one, sampled on the first step of a job |
| a_valid_i | input | 1 | Left-operand slice valid |
| a_ready_o | output | 1 | Left-operand slice ready |
| a_col_i | input | ROWS*OP_W | Column slice of the left matrix, lane i goes to row i |
| b_valid_i | input | 1 | Right-operand slice valid |
| b_ready_o | output | 1 | Right-operand slice ready |
| b_row_i | input | COLS*OP_W | Row slice of the right matrix, lane j goes to column j |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result ready |
| res_data_o | output | ACC_W | Result value |
| res_last_o | output | 1 | Final result of the job |

## Verification
The bound checker checks the following on every cycle:
- The pipeline holds still on cycles without a step.
- Results are held under backpressure.
- Input and output handshakes exclude each other.
- The number of results before the last-result flag is correct.
- The accumulator is clear once draining ends.

The arithmetic can only be shown by the bench's directed scenarios, which compare every drained value against a product computed in the bench. These cover the broadcast lane mapping, the interleaving of tiles, the sampling of the K length, wrap-around and clearing between jobs. Input gaps and output backpressure are applied at random.

// File: rtl/opm_pkg.sv
package opm_pkg;

    typedef enum logic {
        ACC_NARROW = 1'b0,
        ACC_WIDE   = 1'b1
    } acc_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_DRAIN = 2'd2
    } mesh_state_e;

    function automatic int acc_width(acc_fmt_e fmt);
        return (fmt == ACC_WIDE) ? 32 : 16;
    endfunction

endpackage

// File: rtl/opm_ctrl.sv
module opm_ctrl
    import opm_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int PIPE_L = 4,
    parameter int K_W    = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [K_W-1:0]             k_last_i,
    input  logic                       a_valid_i,
    input  logic                       b_valid_i,
    input  logic                       res_ready_i,
    output logic                       in_ready_o,
    output logic                       step_o,
    output logic                       first_o,
    output logic                       clr_o,
    output logic                       res_valid_o,
    output logic                       res_last_o,
    output logic [$clog2(ROWS*COLS)-1:0] elem_o
);

    localparam int ELEMS  = ROWS * COLS;
    localparam int ELEM_W = $clog2(ELEMS);
    localparam int SLOT_W = (PIPE_L > 1) ? $clog2(PIPE_L) : 1;

    mesh_state_e state_q, state_d;

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] tile_q;
    logic [K_W-1:0]    kcnt_q;
    logic [K_W-1:0]    klim_q;
    logic [ELEM_W-1:0] elem_q;

    logic [K_W-1:0] klim_eff;
    logic           slot_end;
    logic           last_step;
    logic           step;
    logic           drain_hs;
    logic           elem_end;
    logic           tile_end;

    // The K limit is live during IDLE, latched afterwards.
    assign klim_eff  = (state_q == ST_IDLE) ? k_last_i : klim_q;
    assign slot_end  = (slot_q == SLOT_W'(PIPE_L - 1));
    assign last_step = slot_end && (kcnt_q == klim_eff);
    assign step      = a_valid_i && b_valid_i && (state_q != ST_DRAIN);
    assign drain_hs  = (state_q == ST_DRAIN) && res_ready_i;
    assign elem_end  = (elem_q == ELEM_W'(ELEMS - 1));
    assign tile_end  = (tile_q == SLOT_W'(PIPE_L - 1));

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (step) begin
                    state_d = last_step ? ST_DRAIN : ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (step && last_step) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (drain_hs && elem_end && tile_end) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready_o  = 1'b0;
        res_valid_o = 1'b0;
        res_last_o  = 1'b0;
        clr_o       = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ACCUM: begin
                in_ready_o = 1'b1;
            end
            ST_DRAIN: begin
                res_valid_o = 1'b1;
                res_last_o  = elem_end && tile_end;
                clr_o       = drain_hs && elem_end;
            end
            default: ;
        endcase
    end

    assign step_o  = step;
    assign first_o = (kcnt_q == '0);
    assign elem_o  = elem_q;

    // Step and drain counters
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q <= '0;
            kcnt_q <= '0;
            klim_q <= '0;
            elem_q <= '0;
            tile_q <= '0;
        end else begin
            if (step) begin
                if (state_q == ST_IDLE) begin
                    klim_q <= k_last_i;
                end
                if (last_step) begin
                    slot_q <= '0;
                    kcnt_q <= '0;
                end else if (slot_end) begin
                    slot_q <= '0;
                    kcnt_q <= kcnt_q + 1'b1;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
            if (drain_hs) begin
                if (elem_end) begin
                    elem_q <= '0;
                    tile_q <= tile_end ? '0 : tile_q + 1'b1;
                end else begin
                    elem_q <= elem_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/opm_pe.sv
module opm_pe #(
    parameter int OP_W   = 8,
    parameter int ACC_W  = 16,
    parameter int PIPE_L = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             first_i,
    input  logic             clr_i,
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    output logic [ACC_W-1:0] tail_o
);

    // Each stage holds the partial sum of one interleaved tile.
    logic [ACC_W-1:0] pipe_q [PIPE_L];
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] head;

    assign prod   = ACC_W'(a_i) * ACC_W'(b_i);
    assign head   = (first_i ? '0 : pipe_q[PIPE_L-1]) + prod;
    assign tail_o = pipe_q[PIPE_L-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < PIPE_L; i++) begin
                pipe_q[i] <= '0;
            end
        end else if (step_i) begin
            pipe_q[0] <= head;
            for (int i = 1; i < PIPE_L; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end else if (clr_i) begin
            pipe_q[0] <= '0;
            for (int i = 1; i < PIPE_L; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

endmodule

// File: rtl/opm_sel.sv
module opm_sel #(
    parameter int COUNT = 64,
    parameter int ACC_W = 16
) (
    input  logic [COUNT*ACC_W-1:0]   tails_i,
    input  logic [$clog2(COUNT)-1:0] idx_i,
    output logic [ACC_W-1:0]         data_o
);

    always_comb begin
        data_o = '0;
        for (int e = 0; e < COUNT; e++) begin
            if (idx_i == $clog2(COUNT)'(e)) begin
                data_o = tails_i[e*ACC_W +: ACC_W];
            end
        end
    end

endmodule

// File: rtl/opm_mesh.sv
module opm_mesh
    import opm_pkg::*;
#(
    parameter int       ROWS    = 8,
    parameter int       COLS    = 8,
    parameter int       PIPE_L  = 4,
    parameter int       OP_W    = 8,
    parameter acc_fmt_e ACC_FMT = ACC_NARROW,
    parameter int       K_W     = 8,
    localparam int      ACC_W   = acc_width(ACC_FMT)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [K_W-1:0]       k_last_i,
    input  logic                 a_valid_i,
    output logic                 a_ready_o,
    input  logic [ROWS*OP_W-1:0] a_col_i,
    input  logic                 b_valid_i,
    output logic                 b_ready_o,
    input  logic [COLS*OP_W-1:0] b_row_i,
    output logic                 res_valid_o,
    input  logic                 res_ready_i,
    output logic [ACC_W-1:0]     res_data_o,
    output logic                 res_last_o
);

    localparam int ELEMS  = ROWS * COLS;
    localparam int ELEM_W = $clog2(ELEMS);

    if ((ROWS & (ROWS - 1)) != 0 || (COLS & (COLS - 1)) != 0) begin : g_bad_dims
        $error("mesh height and width must be powers of two");
    end

    logic                   in_ready;
    logic                   step;
    logic                   first;
    logic                   clr;
    logic [ELEM_W-1:0]      elem;
    logic [ELEMS*ACC_W-1:0] tails;

    opm_ctrl #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .PIPE_L(PIPE_L),
        .K_W   (K_W)
    ) i_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .k_last_i   (k_last_i),
        .a_valid_i  (a_valid_i),
        .b_valid_i  (b_valid_i),
        .res_ready_i(res_ready_i),
        .in_ready_o (in_ready),
        .step_o     (step),
        .first_o    (first),
        .clr_o      (clr),
        .res_valid_o(res_valid_o),
        .res_last_o (res_last_o),
        .elem_o     (elem)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            opm_pe #(
                .OP_W  (OP_W),
                .ACC_W (ACC_W),
                .PIPE_L(PIPE_L)
            ) i_pe (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .step_i (step),
                .first_i(first),
                .clr_i  (clr),
                .a_i    (a_col_i[r*OP_W +: OP_W]),
                .b_i    (b_row_i[c*OP_W +: OP_W]),
                .tail_o (tails[(r*COLS+c)*ACC_W +: ACC_W])
            );
        end
    end

    opm_sel #(
        .COUNT(ELEMS),
        .ACC_W(ACC_W)
    ) i_sel (
        .tails_i(tails),
        .idx_i  (elem),
        .data_o (res_data_o)
    );

    assign a_ready_o = in_ready;
    assign b_ready_o = in_ready;

endmodule

// File: rtl/opm_mesh_chk.sv
module opm_mesh_chk #(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int PIPE_L = 4,
    parameter int ACC_W  = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             a_valid_i,
    input logic             b_valid_i,
    input logic             a_ready_i,
    input logic             b_ready_i,
    input logic             res_valid_i,
    input logic             res_ready_i,
    input logic [ACC_W-1:0] res_data_i,
    input logic             res_last_i,
    input logic [ACC_W-1:0] tail0_i
);

    localparam int TOTAL = PIPE_L * ROWS * COLS;
    localparam int CNT_W = $clog2(TOTAL) + 1;

    logic [CNT_W-1:0] out_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_cnt <= '0;
        end else if (res_valid_i && res_ready_i) begin
            out_cnt <= res_last_i ? '0 : out_cnt + 1'b1;
        end
    end

    assert_freeze_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_ready_i && !(a_valid_i && b_valid_i) && !res_valid_i) |=> $stable(tail0_i));

    assert_full_rate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !res_valid_i |-> (a_ready_i && b_ready_i));

    assert_no_input_in_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_i |-> (!a_ready_i && !b_ready_i));

    assert_last_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_i && res_ready_i && res_last_i) |-> (out_cnt == CNT_W'(TOTAL - 1)));

    assert_last_with_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_last_i |-> res_valid_i);

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_i && !res_ready_i) |=>
            (res_valid_i && $stable(res_data_i) && $stable(res_last_i)));

    assert_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(res_valid_i) |-> (tail0_i == '0));

endmodule

bind opm_mesh opm_mesh_chk #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .PIPE_L(PIPE_L),
    .ACC_W (ACC_W)
) i_opm_mesh_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_valid_i  (a_valid_i),
    .b_valid_i  (b_valid_i),
    .a_ready_i  (a_ready_o),
    .b_ready_i  (b_ready_o),
    .res_valid_i(res_valid_o),
    .res_ready_i(res_ready_i),
    .res_data_i (res_data_o),
    .res_last_i (res_last_o),
    .tail0_i    (tails[ACC_W-1:0])
);

// File: tb/test_opm_mesh.sv
module test_opm_mesh;
    import opm_pkg::*;

    localparam int ROWS  = 8;
    localparam int COLS  = 8;
    localparam int L     = 4;
    localparam int OP_W  = 8;
    localparam int ACC_W = 16;
    localparam int K_W   = 8;
    localparam int KMAX  = 12;
    localparam int ELEMS = ROWS * COLS;
    localparam int TOTAL = L * ELEMS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [K_W-1:0]       k_last = '0;
    logic                 a_valid = 1'b0;
    logic                 a_ready;
    logic [ROWS*OP_W-1:0] a_col = '0;
    logic                 b_valid = 1'b0;
    logic                 b_ready;
    logic [COLS*OP_W-1:0] b_row = '0;
    logic                 res_valid;
    logic                 res_ready = 1'b0;
    logic [ACC_W-1:0]     res_data;
    logic                 res_last;

    int a_m [L][ROWS][KMAX];
    int b_m [L][KMAX][COLS];
    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    opm_mesh #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .PIPE_L (L),
        .OP_W   (OP_W),
        .ACC_FMT(ACC_NARROW),
        .K_W    (K_W)
    ) i_opm_mesh (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .k_last_i   (k_last),
        .a_valid_i  (a_valid),
        .a_ready_o  (a_ready),
        .a_col_i    (a_col),
        .b_valid_i  (b_valid),
        .b_ready_o  (b_ready),
        .b_row_i    (b_row),
        .res_valid_o(res_valid),
        .res_ready_i(res_ready),
        .res_data_o (res_data),
        .res_last_o (res_last)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode 0 random, 1 lane pattern, 2 all max, 3 zeros
    task automatic fill(int mode);
        for (int s = 0; s < L; s++) begin
            for (int k = 0; k < KMAX; k++) begin
                for (int i = 0; i < ROWS; i++) begin
                    case (mode)
                        0: a_m[s][i][k] = int'($urandom_range(255));
                        1: a_m[s][i][k] = i + 1 + 8 * s;
                        2: a_m[s][i][k] = 255;
                        default: a_m[s][i][k] = 0;
                    endcase
                end
                for (int j = 0; j < COLS; j++) begin
                    case (mode)
                        0: b_m[s][k][j] = int'($urandom_range(255));
                        1: b_m[s][k][j] = j + 1;
                        2: b_m[s][k][j] = 255;
                        default: b_m[s][k][j] = 0;
                    endcase
                end
            end
        end
    endtask

    function automatic longint expect_val(int s, int r, int c, int klast);
        longint acc = 0;
        for (int k = 0; k <= klast; k++) begin
            acc += longint'(a_m[s][r][k]) * longint'(b_m[s][k][c]);
        end
        return acc & ((longint'(1) << ACC_W) - 1);
    endfunction

    task automatic drive_slices(int s, int k);
        for (int i = 0; i < ROWS; i++) a_col[i*OP_W +: OP_W] = OP_W'(a_m[s][i][k]);
        for (int j = 0; j < COLS; j++) b_row[j*OP_W +: OP_W] = OP_W'(b_m[s][k][j]);
    endtask

    task automatic run_job(string req, int klast, int gap_pct, int bp_pct);
        int idx = 0;
        int guard = 0;
        bit held = 1'b0;
        logic [ACC_W-1:0] hold_d = '0;
        @(negedge clk);
        k_last = K_W'(klast);
        for (int k = 0; k <= klast; k++) begin
            for (int s = 0; s < L; s++) begin
                while (int'($urandom_range(99)) < gap_pct) begin
                    drive_slices(s, k);
                    // lone valid stream, garbage on the other (R2)
                    if ($urandom_range(1) == 1) begin
                        a_valid = 1'b1; b_valid = 1'b0; b_row = {COLS{8'hA5}};
                    end else begin
                        a_valid = 1'b0; b_valid = 1'b1; a_col = {ROWS{8'h5A}};
                    end
                    @(negedge clk);
                end
                drive_slices(s, k);
                a_valid = 1'b1;
                b_valid = 1'b1;
                #1;
                check(a_ready && b_ready, "R5", "input ready during job", longint'(a_ready), 1);
                @(posedge clk);
                @(negedge clk);
                if (k == 0 && s == 0) k_last = K_W'($urandom_range(255)); // R6
            end
        end
        a_valid = 1'b0;
        b_valid = 1'b0;
        while (idx < TOTAL && guard < 20000) begin
            res_ready = (int'($urandom_range(99)) >= bp_pct);
            #1;
            if (held) begin
                check(res_valid && res_data == hold_d, "R8", "held result", longint'(res_data), longint'(hold_d));
                held = 1'b0;
            end
            check(res_valid && !a_ready && !b_ready, "R7", "draining flags", longint'(res_valid), 1);
            if (res_valid && res_ready) begin
                int s = idx / ELEMS;
                int r = (idx % ELEMS) / COLS;
                int c = idx % COLS;
                longint ev = expect_val(s, r, c, klast);
                check(res_data == ACC_W'(ev), req, $sformatf("tile %0d C[%0d][%0d]", s, r, c),
                      longint'(res_data), ev);
                check(res_last == (idx == TOTAL - 1), "R7", "last flag", longint'(res_last),
                      longint'(idx == TOTAL - 1));
                idx++;
            end else if (res_valid) begin
                held = 1'b1;
                hold_d = res_data;
            end
            @(negedge clk);
            guard++;
        end
        res_ready = 1'b0;
        #1;
        check(idx == TOTAL, "R7", "result count", idx, TOTAL);
        check(!res_valid && a_ready && b_ready, "R7", "back to accepting", longint'(a_ready), 1);
    endtask

    task automatic t_reset;
        #1;
        check(a_ready && b_ready, "R1", "input ready after reset", longint'(a_ready), 1);
        check(!res_valid, "R1", "result valid after reset", longint'(res_valid), 0);
    endtask

    task automatic t_broadcast;   // R3 R4
        fill(1);
        run_job("R3/R4", 0, 0, 0);
    endtask

    task automatic t_full_rate;   // R5 R6
        fill(0);
        run_job("R5", 5, 0, 0);
    endtask

    task automatic t_gaps;        // R2
        fill(0);
        run_job("R2", int'($urandom_range(KMAX - 1)), 40, 0);
    endtask

    task automatic t_backpressure; // R8
        fill(0);
        run_job("R8", 3, 10, 50);
    endtask

    task automatic t_wrap;        // R10: 4*255*255 mod 2^16 = 63492
        fill(2);
        run_job("R10", 3, 0, 0);
    endtask

    task automatic t_clear;       // R9: zero job after a large one
        fill(2);
        run_job("R10", KMAX - 1, 0, 20);
        fill(3);
        run_job("R9", 0, 0, 0);
    endtask

    task automatic t_random_jobs; // R6 mix of lengths
        for (int n = 0; n < 3; n++) begin
            fill(0);
            run_job("R6", int'($urandom_range(KMAX - 1)), 15, 15);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_broadcast();
        t_full_rate();
        t_gaps();
        t_backpressure();
        t_wrap();
        t_clear();
        t_random_jobs();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule